// File: doc/BRIEF.md
# External Sync Arbitration Unit

This block decides, cycle by cycle, whether the switching period of a converter is paced by its internal oscillator or by an external synchronization clock. A rising edge on the external sync input ends the current period and starts a new one. Once such an edge has been accepted, the internal period strobes are suppressed until no further edge arrives within a reassertion window; the block then falls back to the internal strobe. External edges are only accepted once soft-start is complete and no transient condition (startup, shutdown, overvoltage) is flagged.

The block also drives a daisy-chain sync output. It is a square wave that falls at each internal period start and rises half a measured period later. It is held low whenever the block is locked to the external clock or a transient is active. Two delayed strobes model the buck switch-node turn-on and the boost switch-node turn-off as fixed cycle counts after each chosen period start. A strap decoder reports a debug-mode request or a strap fault from the level of the timing pin and the synchronized sync input.

Top module: `cycle_sync_arbiter`

## Requirements
- R1: While rst_n is low, every output is 0.
- R2: The sync input passes through a two-flop synchronizer, and a rising edge is taken from the synchronized level. An accepted edge, meaning one seen while ss_done=1 and transient=0, raises cyc_start for one cycle and sets ext_locked. Both changes show up three clock edges after sync_in rises.
- R3: While ext_locked is 1, int_tick has no effect on cyc_start. Only accepted sync edges start periods.
- R4: ext_locked stays high for exactly REASSERT_CYC cycles after the cycle in which the last accepted edge raised cyc_start. After that, int_tick paces cyc_start again.
- R5: While ss_done=0 or transient=1, sync edges are ignored and ext_locked is cleared on the next edge.
- R6: Outside hold conditions, sync_out goes low on the edge that samples int_tick. It goes high on the edge at which the count since that tick equals half of the previous tick-to-tick period, rounded down. Before any period has been measured it stays low.
- R7: sync_out is 0 in every cycle in which ext_locked is 1, and it is 0 on the cycle after transient=1 or ss_done=0.
- R8: buck_on repeats cyc_start delayed by BUCK_DLY cycles. boost_off repeats cyc_start delayed by BOOST_DLY cycles.
- R9: debug_mode is 1 one edge after tmr_pin_lo=1 coincides with a synchronized sync level of 1.
- R10: strap_fault is 1 one edge after tmr_pin_lo=1 coincides with a synchronized sync level of 0. It is never 1 together with debug_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int_tick | input | 1 | Internal oscillator period-start strobe |
| sync_in | input | 1 | Asynchronous external sync clock |
| ss_done | input | 1 | Soft-start complete |
| transient | input | 1 | Startup, shutdown or overvoltage condition |
| tmr_pin_lo | input | 1 | Watchdog timing pin is held low (strap) |
| cyc_start | output | 1 | Chosen period-start strobe |
| ext_locked | output | 1 | Paced by external clock; spread spectrum off |
| sync_out | output | 1 | Daisy-chain sync output level |
| buck_on | output | 1 | Buck switch-node turn-on strobe |
| boost_off | output | 1 | Boost switch-node turn-off strobe |
| debug_mode | output | 1 | Debug mode decoded from straps |
| strap_fault | output | 1 | Timing pin low without sync high |

## Verification
The hardest situation to reach from the ports is the exact fallback boundary. The lock has to lapse while internal ticks keep running, and a late sync edge has to land near the end of the reassertion window, either just inside it or just past it. The stimulus gets there by mixing random sync gaps that straddle REASSERT_CYC with random transient pulses and running internal ticks. A cycle-level reference model predicts every output on every cycle. Directed phases also count period starts inside a locked window and watch the lock lapse after the sync clock stops.

// File: rtl/sa_pkg.sv
// Shared types for the sync arbitration unit.
// Assumes: nothing beyond IEEE 1800-2017.
package sa_pkg;
    // Which source currently paces the switching period
    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_EXTERNAL = 1'b1
    } pace_src_e;
endpackage

// File: rtl/sa_sync_edge.sv
// Multi-flop synchronizer for an asynchronous level, with rising-edge
// detection taken from the synchronized level.
// Assumes: STAGES >= 2; async_in may change at any time.
module sa_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] pipe_q;
    logic              last_q;

    // Shift the raw input through the synchronizer, keep previous level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
            last_q <= 1'b0;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], async_in};
            last_q <= pipe_q[STAGES-1];
        end
    end

    assign level = pipe_q[STAGES-1];
    assign rise  = pipe_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/sa_lock_ctrl.sv
// Chooses the period source. Accepted external edges start a period and
// lock the block; a missing edge within TMO cycles releases the lock.
// Assumes: rise is a single-cycle strobe in the clk domain; TMO >= 2.
module sa_lock_ctrl
    import sa_pkg::*;
#(
    parameter int TMO = 130
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic int_tick,
    input  logic ss_done,
    input  logic transient,
    output logic cyc_start,
    output logic locked,
    output logic hold
);
    localparam int TW = $clog2(TMO + 1);
    localparam logic [TW-1:0] TLAST = TW'(TMO - 1);

    pace_src_e       src_q;
    logic [TW-1:0]   tmo_q;
    logic            allow;
    logic            accept;

    assign allow  = ss_done & ~transient;
    assign accept = rise & allow;
    assign locked = (src_q == SRC_EXTERNAL);
    assign hold   = locked | accept | ~allow;

    // Track source selection and the reassertion window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= SRC_INTERNAL;
            tmo_q <= '0;
        end else if (!allow) begin
            src_q <= SRC_INTERNAL;
            tmo_q <= '0;
        end else if (accept) begin
            src_q <= SRC_EXTERNAL;
            tmo_q <= '0;
        end else if (src_q == SRC_EXTERNAL) begin
            if (tmo_q == TLAST) begin
                src_q <= SRC_INTERNAL;
                tmo_q <= '0;
            end else begin
                tmo_q <= tmo_q + 1'b1;
            end
        end
    end

    // Register the chosen period-start strobe
    always_ff @(posedge clk) begin
        if (!rst_n) cyc_start <= 1'b0;
        else        cyc_start <= accept | (int_tick & ~locked);
    end
endmodule

// File: rtl/sa_sync_out_gen.sv
// Builds the daisy-chain sync output: low at each internal tick, high
// half a measured period later; forced low while hold is asserted.
// Assumes: int_tick is a single-cycle strobe; periods fit in PW bits.
module sa_sync_out_gen #(
    parameter int PW = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic int_tick,
    input  logic hold,
    output logic sync_out
);
    localparam logic [PW-1:0] PMAX = '1;

    logic [PW-1:0] ph_q;
    logic [PW-1:0] per_q;

    // Measure cycles since the last tick and latch the last period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= '0;
            per_q <= '0;
        end else if (int_tick) begin
            ph_q  <= PW'(1);
            per_q <= ph_q;
        end else if (ph_q != PMAX) begin
            ph_q  <= ph_q + 1'b1;
        end
    end

    // Drive the square wave level
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_out <= 1'b0;
        else if (hold || int_tick)
            sync_out <= 1'b0;
        else if ((per_q != '0) && (ph_q == (per_q >> 1)))
            sync_out <= 1'b1;
    end
endmodule

// File: rtl/sa_delay.sv
// Fixed delay of a strobe by DLY clock cycles (DLY = 0 passes through).
// Assumes: DLY is small enough for a shift register.
module sa_delay #(
    parameter int DLY = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (DLY == 0) begin : g_pass
            assign q = d;
        end else if (DLY == 1) begin : g_one
            logic r_q;
            // Single-stage delay
            always_ff @(posedge clk) begin
                if (!rst_n) r_q <= 1'b0;
                else        r_q <= d;
            end
            assign q = r_q;
        end else begin : g_shift
            logic [DLY-1:0] sr_q;
            // Shift the strobe along the delay line
            always_ff @(posedge clk) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= {sr_q[DLY-2:0], d};
            end
            assign q = sr_q[DLY-1];
        end
    endgenerate
endmodule

// File: rtl/cycle_sync_arbiter.sv
// Top of the sync arbitration unit: synchronizes the external sync input,
// selects the period source, generates the daisy-chain output, the
// switch-node strobes and the strap decode.
// Assumes: all inputs except sync_in are synchronous to clk.
module cycle_sync_arbiter #(
    parameter int SYNC_STAGES  = 2,
    parameter int REASSERT_CYC = 130,
    parameter int BUCK_DLY     = 18,
    parameter int BOOST_DLY    = 70,
    parameter int PERIOD_W     = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic int_tick,
    input  logic sync_in,
    input  logic ss_done,
    input  logic transient,
    input  logic tmr_pin_lo,
    output logic cyc_start,
    output logic ext_locked,
    output logic sync_out,
    output logic buck_on,
    output logic boost_off,
    output logic debug_mode,
    output logic strap_fault
);
    logic sync_lvl;
    logic sync_rise;
    logic out_hold;

    sa_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sync_in),
        .level(sync_lvl), .rise(sync_rise)
    );

    sa_lock_ctrl #(.TMO(REASSERT_CYC)) u_lock (
        .clk(clk), .rst_n(rst_n), .rise(sync_rise), .int_tick(int_tick),
        .ss_done(ss_done), .transient(transient),
        .cyc_start(cyc_start), .locked(ext_locked), .hold(out_hold)
    );

    sa_sync_out_gen #(.PW(PERIOD_W)) u_sout (
        .clk(clk), .rst_n(rst_n), .int_tick(int_tick),
        .hold(out_hold), .sync_out(sync_out)
    );

    sa_delay #(.DLY(BUCK_DLY)) u_buck_dly (
        .clk(clk), .rst_n(rst_n), .d(cyc_start), .q(buck_on)
    );

    sa_delay #(.DLY(BOOST_DLY)) u_boost_dly (
        .clk(clk), .rst_n(rst_n), .d(cyc_start), .q(boost_off)
    );

    // Decode the strap pins into debug request or fault
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            debug_mode  <= 1'b0;
            strap_fault <= 1'b0;
        end else begin
            debug_mode  <= tmr_pin_lo & sync_lvl;
            strap_fault <= tmr_pin_lo & ~sync_lvl;
        end
    end
endmodule

// File: rtl/sa_checker.sv
// Temporal checks for the sync arbitration unit, bound to the top.
// Assumes: rise is the internal synchronized edge strobe of the top.
module sa_checker #(
    parameter int TMO = 130
) (
    input logic clk,
    input logic rst_n,
    input logic ss_done,
    input logic transient,
    input logic rise,
    input logic cyc_start,
    input logic ext_locked,
    input logic sync_out,
    input logic debug_mode,
    input logic strap_fault
);
    localparam int CW = $clog2(TMO + 2);
    localparam logic [CW-1:0] CMAX = '1;
    logic [CW-1:0] since_q;

    // Count cycles since the last period start, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)         since_q <= CMAX;
        else if (cyc_start) since_q <= CW'(1);
        else if (since_q != CMAX) since_q <= since_q + 1'b1;
    end

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && ss_done && !transient) |=> (cyc_start && ext_locked));

    assert_tick_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_locked && !rise) |=> !cyc_start);

    assert_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_locked && !cyc_start) |-> (since_q < CW'(TMO)));

    assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_done || transient) |=> !ext_locked);

    assert_low_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_locked |-> !sync_out);

    assert_low_transient_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (transient || !ss_done) |=> !sync_out);

    assert_strap_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(debug_mode && strap_fault));
endmodule

bind cycle_sync_arbiter sa_checker #(.TMO(REASSERT_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .ss_done(ss_done), .transient(transient),
    .rise(sync_rise), .cyc_start(cyc_start), .ext_locked(ext_locked),
    .sync_out(sync_out), .debug_mode(debug_mode), .strap_fault(strap_fault)
);

// File: tb/test_cycle_sync_arbiter.sv
module test_cycle_sync_arbiter;
    localparam int TMO   = 130;
    localparam int BDLY  = 18;
    localparam int ODLY  = 70;
    localparam int PW    = 10;
    localparam int TICKP = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic int_tick = 1'b0, sync_in = 1'b0, ss_done = 1'b0;
    logic transient = 1'b0, tmr_pin_lo = 1'b0;
    logic cyc_start, ext_locked, sync_out, buck_on, boost_off;
    logic debug_mode, strap_fault;
    logic tick_en = 1'b0;
    int   tcnt = 0;
    int   total = 0, bad = 0, cycles = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    cycle_sync_arbiter #(.REASSERT_CYC(TMO), .BUCK_DLY(BDLY),
                         .BOOST_DLY(ODLY), .PERIOD_W(PW)) i_cycle_sync_arbiter (
        .clk(clk), .rst_n(rst_n), .int_tick(int_tick), .sync_in(sync_in),
        .ss_done(ss_done), .transient(transient), .tmr_pin_lo(tmr_pin_lo),
        .cyc_start(cyc_start), .ext_locked(ext_locked), .sync_out(sync_out),
        .buck_on(buck_on), .boost_off(boost_off),
        .debug_mode(debug_mode), .strap_fault(strap_fault));

    // ---------------- reference model (from the requirements) -------------
    logic m_p1, m_p2, m_last, m_lock, m_cyc, m_so, m_dbg, m_flt;
    int   m_cnt;
    logic [PW-1:0] m_ph, m_per;
    logic [127:0]  m_hist;

    always @(posedge clk) begin : model
        logic rise_v, allow_v, acc_v, hold_v;
        if (!rst_n) begin
            m_p1 <= 0; m_p2 <= 0; m_last <= 0; m_lock <= 0; m_cyc <= 0;
            m_so <= 0; m_dbg <= 0; m_flt <= 0; m_cnt <= 0;
            m_ph <= 0; m_per <= 0; m_hist <= '0;
        end else begin
            rise_v  = m_p2 & ~m_last;
            allow_v = ss_done & ~transient;
            acc_v   = rise_v & allow_v;
            hold_v  = m_lock | acc_v | ~allow_v;
            m_p1 <= sync_in; m_p2 <= m_p1; m_last <= m_p2;
            if (!allow_v) begin m_lock <= 0; m_cnt <= 0; end
            else if (acc_v) begin m_lock <= 1; m_cnt <= 0; end
            else if (m_lock) begin
                if (m_cnt == TMO - 1) begin m_lock <= 0; m_cnt <= 0; end
                else m_cnt <= m_cnt + 1;
            end
            m_cyc  <= acc_v | (int_tick & ~m_lock);
            m_hist <= {m_hist[126:0], m_cyc};
            if (int_tick) begin m_ph <= 1; m_per <= m_ph; end
            else if (m_ph != '1) m_ph <= m_ph + 1'b1;
            if (hold_v || int_tick) m_so <= 0;
            else if (m_per != 0 && m_ph == (m_per >> 1)) m_so <= 1;
            m_dbg <= tmr_pin_lo & m_p2;
            m_flt <= tmr_pin_lo & ~m_p2;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Compare every output to the model away from the clock edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            check("R2 cyc_start",   cyc_start,   m_cyc);
            check("R4 ext_locked",  ext_locked,  m_lock);
            check("R6 sync_out",    sync_out,    m_so);
            check("R8 buck_on",     buck_on,     m_hist[BDLY-1]);
            check("R8 boost_off",   boost_off,   m_hist[ODLY-1]);
            check("R9 debug_mode",  debug_mode,  m_dbg);
            check("R10 strap_fault", strap_fault, m_flt);
        end
    end

    // Internal oscillator strobe generator
    always @(negedge clk) begin
        if (tick_en) begin
            int_tick = (tcnt == TICKP - 1);
            tcnt = (tcnt == TICKP - 1) ? 0 : tcnt + 1;
        end else begin
            int_tick = 1'b0;
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    // One sync period, counting period starts seen during it
    task automatic sync_period(input int hi, input int lo, output int c);
        c = 0;
        for (int i = 0; i < hi + lo; i++) begin
            @(negedge clk);
            sync_in = (i < hi);
            #0.1;
            if (cyc_start) c++;
        end
    endtask

    initial begin
        int c;
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1 reset", cyc_start | ext_locked | sync_out | buck_on |
                          boost_off | debug_mode | strap_fault, 1'b0);
        sync_in = 1'b1; tmr_pin_lo = 1'b1; tick_en = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 reset held", cyc_start | ext_locked | debug_mode | strap_fault, 1'b0);
        sync_in = 1'b0; tmr_pin_lo = 1'b0;
        @(negedge clk); rst_n = 1'b1;

        // R5: soft-start not done, edges ignored
        for (int k = 0; k < 3; k++) begin
            sync_period(10, 30, c);
            check("R5 no lock before soft-start", ext_locked, 1'b0);
        end
        ss_done = 1'b1;
        repeat (200) @(negedge clk);      // R6 wave against the model

        // R2/R3/R7: lock on a 40-cycle external clock
        for (int k = 0; k < 3; k++) sync_period(20, 20, c);
        check("R2 locked", ext_locked, 1'b1);
        sync_period(20, 20, c);
        check("R3 one start per sync period", (c == 1), 1'b1);
        check("R7 sync_out low while locked", sync_out, 1'b0);

        // R4: clock stops, lock lapses after the window
        repeat (50) @(negedge clk);
        check("R4 still inside window", ext_locked, 1'b1);
        repeat (100) @(negedge clk);
        check("R4 fallback after window", ext_locked, 1'b0);

        // R5: transient blocks locking
        transient = 1'b1;
        for (int k = 0; k < 3; k++) begin
            sync_period(10, 30, c);
            check("R5 no lock in transient", ext_locked, 1'b0);
            check("R7 sync_out low in transient", sync_out, 1'b0);
        end
        transient = 1'b0;

        // Random mix: gaps around the reassertion window
        for (int k = 0; k < 120; k++) begin
            int hi, lo;
            hi = 1 + int'($urandom_range(15));
            lo = 2 + int'($urandom_range(TMO + 20));
            if (k % 10 == 3) lo = TMO - 6 + int'($urandom_range(8));
            transient  = ($urandom_range(15) == 0);
            ss_done    = ($urandom_range(20) != 0);
            tmr_pin_lo = ($urandom_range(3) == 0);
            sync_period(hi, lo, c);
        end
        transient = 1'b0; ss_done = 1'b1; tmr_pin_lo = 1'b0;

        // R9/R10: strap decode
        sync_in = 1'b1; tmr_pin_lo = 1'b1;
        repeat (6) @(negedge clk);
        check("R9 debug request", debug_mode, 1'b1);
        check("R10 no fault with sync high", strap_fault, 1'b0);
        sync_in = 1'b0;
        repeat (6) @(negedge clk);
        check("R10 strap fault", strap_fault, 1'b1);
        check("R9 debug cleared", debug_mode, 1'b0);
        tmr_pin_lo = 1'b0;
        repeat (ODLY + 10) @(negedge clk);
        finish_run();
    end
endmodule